// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges five independent reset requests into one system reset that is synchronous to the block clock. It also keeps a small cause register that software can read to find out which source or sources caused the last reset. The five sources are a power-on supply flag, an active-low external reset pin, a brown-out flag gated by its own enable, a reset bit held by the test access port, and a pulse from the watchdog when it expires. The analog comparators that produce the supply flags are not part of this block. Here they are plain digital inputs that are already in the clock domain.

The external pin is asynchronous. It passes through a two-stage synchronizer and then a run-length filter, so short glitches cannot reset the chip. When every request has gone away, the reset output stays high for a further fixed stretch of cycles. This gives the rest of the chip a clean release. The power-on flag also acts as this block's own initialisation. Software clears cause bits with a write-one-to-clear strobe.

Top module: `rstc_top`

## Requirements
- R1: While `porFlag` is high, `sysRst` is high and, from the next edge on, `causeFlags` reads 5'b00001. Bit 0 is the power-on cause, and power-on clears every other cause bit.
- R2: The external pin is sampled through two flops. A low level seen for MIN_LEN cycles or fewer (default 4) is ignored. A low level lasting MIN_LEN+1 cycles requests reset and sets cause bit 1.
- R3: `bodFlag` requests reset and sets cause bit 2 only while `bodEnable` is high. With the enable low, the flag has no effect on `sysRst` or on the cause bits.
- R4: `jtagRstBit` holds `sysRst` high for every cycle it is one and sets cause bit 4.
- R5: A single-cycle `wdogExpire` pulse requests reset and sets cause bit 3.
- R6: After the last clock edge at which any request was seen, `sysRst` stays high for exactly STRETCH further edges (default 16) and then falls.
- R7: A source other than power-on sets only its own cause bit and leaves the other bits unchanged.
- R8: When `causeClrWe` is high, each one in `causeClrData` clears that cause bit at the next edge. A source that is active in the same cycle wins over the clear.
- R9: `sysRst` rises at the first clock edge at which any request is seen and stays high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porFlag | input | 1 | Supply below power-on threshold; also initialises the block |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| bodFlag | input | 1 | Supply below brown-out threshold |
| bodEnable | input | 1 | Brown-out detection enable |
| jtagRstBit | input | 1 | Reset bit from the test access port |
| wdogExpire | input | 1 | Watchdog expiry pulse |
| causeClrWe | input | 1 | Cause clear strobe |
| causeClrData | input | 5 | Write-one-to-clear mask for the cause bits |
| sysRst | output | 1 | Synchronous system reset, active high |
| causeFlags | output | 5 | Cause bits: 0 power-on, 1 pin, 2 brown-out, 3 watchdog, 4 test port |

## Verification
The pin filter has a run counter. If its count were wrong by one, a pulse that is exactly at the limit would either slip through or be dropped. That difference shows on `sysRst` two cycles after the synchronizer delay. The release counter can likewise be off by one, which moves the falling edge of `sysRst` by a single cycle after a power-on or test-port release. Errors in the cause register show at `causeFlags` on the first edge after a set or a clear. A reference model compares both outputs on every cycle, so any of these faults appears in the cycle where it happens.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_CAUSES = 5;
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_EXT  = 1;
  localparam int CAUSE_BOD  = 2;
  localparam int CAUSE_WDOG = 3;
  localparam int CAUSE_JTAG = 4;

  typedef struct packed {
    logic [NUM_CAUSES-1:0] setMask;
    logic                  anyReq;
  } rstcStrobes_t;
endpackage

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int MIN_LEN = 4
) (
  input  logic         clk,
  input  logic         porFlag,
  input  logic         extRstN,
  input  logic         bodFlag,
  input  logic         bodEnable,
  input  logic         jtagRstBit,
  input  logic         wdogExpire,
  output rstcStrobes_t strobes
);
  localparam int LOW_W = $clog2(MIN_LEN + 1) + 1;
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MIN_LEN);

  logic             extSync1;
  logic             extSync2;
  logic [LOW_W-1:0] lowCnt;
  logic             extReq;

  // two-stage synchronizer for the asynchronous pin
  always_ff @(posedge clk) begin
    if (porFlag) begin
      extSync1 <= 1'b1;
      extSync2 <= 1'b1;
    end else begin
      extSync1 <= extRstN;
      extSync2 <= extSync1;
    end
  end

  // run length of the synchronized low level, saturating
  always_ff @(posedge clk) begin
    if (porFlag || extSync2) begin
      lowCnt <= '0;
    end else if (lowCnt != LOW_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign extReq = !extSync2 && (lowCnt == LOW_MAX);

  always_comb begin
    strobes.setMask             = '0;
    strobes.setMask[CAUSE_POR]  = porFlag;
    strobes.setMask[CAUSE_EXT]  = extReq;
    strobes.setMask[CAUSE_BOD]  = bodFlag && bodEnable;
    strobes.setMask[CAUSE_WDOG] = wdogExpire;
    strobes.setMask[CAUSE_JTAG] = jtagRstBit;
    strobes.anyReq              = |strobes.setMask;
  end

  // R2: a pin request needs the pin low now and at the previous sample
  assert_ext_filtered_R2: assert property (@(posedge clk) disable iff (porFlag)
    extReq |-> (!extSync2 && $past(!extSync2)));
endmodule

// File: rtl/rstc_datapath.sv
module rstc_datapath
  import rstc_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic                  clk,
  input  logic                  porFlag,
  input  rstcStrobes_t          strobes,
  input  logic                  causeClrWe,
  input  logic [NUM_CAUSES-1:0] causeClrData,
  output logic                  sysRst,
  output logic [NUM_CAUSES-1:0] causeFlags
);
  localparam int HOLD_W = $clog2(STRETCH + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(STRETCH);

  logic [HOLD_W-1:0]     holdCnt;
  logic [NUM_CAUSES-1:0] clrMask;

  always_ff @(posedge clk) begin
    if (porFlag || strobes.anyReq) begin
      holdCnt <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign sysRst  = (holdCnt != '0);
  assign clrMask = causeClrWe ? causeClrData : '0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CAUSES; gi++) begin : g_cause
      always_ff @(posedge clk) begin
        if (porFlag) begin
          causeFlags[gi] <= (gi == CAUSE_POR);
        end else if (strobes.setMask[gi]) begin
          causeFlags[gi] <= 1'b1;
        end else if (clrMask[gi]) begin
          causeFlags[gi] <= 1'b0;
        end
      end

      // R8: a clear without a matching set empties the bit
      assert_w1c_R8: assert property (@(posedge clk) disable iff (porFlag)
        (causeClrWe && causeClrData[gi] && !strobes.setMask[gi]) |=> !causeFlags[gi]);

      // R7: a set bit stays set unless it is cleared
      assert_sticky_R7: assert property (@(posedge clk) disable iff (porFlag)
        (causeFlags[gi] && !(causeClrWe && causeClrData[gi])) |=> causeFlags[gi]);
    end
  endgenerate

  // R9: a request seen at one edge keeps reset high in the next cycle
  assert_req_holds_R9: assert property (@(posedge clk) disable iff (porFlag)
    $past(strobes.anyReq) |-> sysRst);

  // R1: leaving power-on shows only the power-on cause, with reset active
  assert_por_cause_R1: assert property (@(posedge clk) disable iff (porFlag)
    $fell(porFlag) |-> (sysRst && causeFlags == NUM_CAUSES'(1)));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int MIN_LEN = 4,
  parameter int STRETCH = 16
) (
  input  logic                  clk,
  input  logic                  porFlag,
  input  logic                  extRstN,
  input  logic                  bodFlag,
  input  logic                  bodEnable,
  input  logic                  jtagRstBit,
  input  logic                  wdogExpire,
  input  logic                  causeClrWe,
  input  logic [NUM_CAUSES-1:0] causeClrData,
  output logic                  sysRst,
  output logic [NUM_CAUSES-1:0] causeFlags
);
  rstcStrobes_t strobes;

  rstc_ctrl #(.MIN_LEN(MIN_LEN)) u_ctrl (
    .clk        (clk),
    .porFlag    (porFlag),
    .extRstN    (extRstN),
    .bodFlag    (bodFlag),
    .bodEnable  (bodEnable),
    .jtagRstBit (jtagRstBit),
    .wdogExpire (wdogExpire),
    .strobes    (strobes)
  );

  rstc_datapath #(.STRETCH(STRETCH)) u_dp (
    .clk          (clk),
    .porFlag      (porFlag),
    .strobes      (strobes),
    .causeClrWe   (causeClrWe),
    .causeClrData (causeClrData),
    .sysRst       (sysRst),
    .causeFlags   (causeFlags)
  );

  // R3: the brown-out cause only appears when the detector was enabled
  assert_bod_gate_R3: assert property (@(posedge clk) disable iff (porFlag)
    $rose(causeFlags[CAUSE_BOD]) |-> $past(bodFlag && bodEnable));

  // R4: the test-port bit keeps the system in reset
  assert_jtag_hold_R4: assert property (@(posedge clk) disable iff (porFlag)
    jtagRstBit |=> sysRst);

  // R5: a watchdog pulse leaves its cause bit set
  assert_wdog_cause_R5: assert property (@(posedge clk) disable iff (porFlag)
    wdogExpire |=> causeFlags[CAUSE_WDOG]);
endmodule

// File: tb/tb_rstc_top.sv
module tb_rstc_top;
  localparam int MIN_LEN = 4;
  localparam int STRETCH = 16;

  logic       clk = 1'b0;
  logic       porFlag = 1'b1;
  logic       extRstN = 1'b1;
  logic       bodFlag = 1'b0;
  logic       bodEnable = 1'b0;
  logic       jtagRstBit = 1'b0;
  logic       wdogExpire = 1'b0;
  logic       causeClrWe = 1'b0;
  logic [4:0] causeClrData = '0;
  logic       sysRst;
  logic [4:0] causeFlags;

  always #10 clk = ~clk;

  rstc_top #(.MIN_LEN(MIN_LEN), .STRETCH(STRETCH)) dut (
    .clk(clk), .porFlag(porFlag), .extRstN(extRstN), .bodFlag(bodFlag),
    .bodEnable(bodEnable), .jtagRstBit(jtagRstBit), .wdogExpire(wdogExpire),
    .causeClrWe(causeClrWe), .causeClrData(causeClrData),
    .sysRst(sysRst), .causeFlags(causeFlags)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  int pinDelay[$] = '{1, 1};
  int lowRun = 0;
  int holdLeft = 0;
  int expCause = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int seen;
    int req;
    int setBits;
    started = 1;
    if (porFlag) begin
      pinDelay = '{1, 1};
      lowRun = 0;
      holdLeft = STRETCH;
      expCause = 1;
    end else begin
      seen = pinDelay[1];
      pinDelay.push_front(int'(extRstN));
      void'(pinDelay.pop_back());
      lowRun = (seen == 0) ? lowRun + 1 : 0;
      setBits = 0;
      if (lowRun > MIN_LEN)         setBits |= 2;
      if (bodFlag && bodEnable)     setBits |= 4;
      if (wdogExpire)               setBits |= 8;
      if (jtagRstBit)               setBits |= 16;
      req = (setBits != 0);
      if (causeClrWe) expCause &= ~int'(causeClrData);
      expCause |= setBits;
      if (req) holdLeft = STRETCH;
      else if (holdLeft > 0) holdLeft--;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R9 sysRst vs model", int'(sysRst), int'(holdLeft != 0));
      check("R7 causeFlags vs model", int'(causeFlags), expCause);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    check("R1 reset during power-on", int'(sysRst), 1);
    check("R1 power-on cause", int'(causeFlags), 5'b00001);
    porFlag = 1'b0;
    cyc(15);
    check("R6 still stretched", int'(sysRst), 1);
    cyc(1);
    check("R6 released after stretch", int'(sysRst), 0);

    causeClrWe = 1'b1; causeClrData = 5'b00001;
    cyc(1);
    causeClrWe = 1'b0; causeClrData = '0;
    check("R8 clear power-on bit", int'(causeFlags), 0);

    extRstN = 1'b0; cyc(MIN_LEN); extRstN = 1'b1;
    cyc(10);
    check("R2 short pulse no reset", int'(sysRst), 0);
    check("R2 short pulse no cause", int'(causeFlags), 0);

    extRstN = 1'b0; cyc(MIN_LEN + 1); extRstN = 1'b1;
    cyc(4);
    check("R2 long pulse resets", int'(sysRst), 1);
    check("R2 pin cause", int'(causeFlags), 5'b00010);
    cyc(30);

    bodFlag = 1'b1; cyc(5); bodFlag = 1'b0; cyc(2);
    check("R3 disabled brown-out no reset", int'(sysRst), 0);
    check("R3 disabled brown-out no cause", int'(causeFlags[2]), 0);
    bodEnable = 1'b1; bodFlag = 1'b1; cyc(2);
    check("R3 enabled brown-out resets", int'(sysRst), 1);
    check("R3 brown-out cause", int'(causeFlags), 5'b00110);
    bodFlag = 1'b0; bodEnable = 1'b0; cyc(25);

    jtagRstBit = 1'b1; cyc(40);
    check("R4 held by test port", int'(sysRst), 1);
    jtagRstBit = 1'b0; cyc(15);
    check("R4 stretch after test port", int'(sysRst), 1);
    cyc(1);
    check("R4 released", int'(sysRst), 0);

    wdogExpire = 1'b1; cyc(1); wdogExpire = 1'b0; cyc(1);
    check("R5 watchdog resets", int'(sysRst), 1);
    check("R7 other causes kept", int'(causeFlags), 5'b11110);

    causeClrWe = 1'b1; causeClrData = 5'b01010; cyc(1);
    causeClrWe = 1'b0; causeClrData = '0;
    check("R8 partial clear", int'(causeFlags), 5'b10100);

    wdogExpire = 1'b1; causeClrWe = 1'b1; causeClrData = 5'b01000; cyc(1);
    wdogExpire = 1'b0; causeClrWe = 1'b0; causeClrData = '0;
    check("R8 set wins over clear", int'(causeFlags[3]), 1);
    cyc(20);

    porFlag = 1'b1; cyc(2);
    check("R1 power-on wipes causes", int'(causeFlags), 5'b00001);
    check("R1 reset asserted", int'(sysRst), 1);
    porFlag = 1'b0; cyc(20);
    check("R6 idle after power-on", int'(sysRst), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule